// File: doc/BRIEF.md
# Accumulator Memory-Operand Unit

This block holds an 8-bit accumulator next to a small byte-wide data memory. It executes one decoded operation at a time: a load into the accumulator, an exchange of the accumulator with a memory byte, or a single-bit set, clear or test on a memory byte. The operand location comes from one of several address modes. The operand byte can be used directly as the address. The address can come from one of two pointer registers, P0 or P1, with the pointer either left alone, post-incremented or post-decremented. For loads only, the operand byte can be taken as the data itself.

Both pointers also appear in the data address map. A load, an exchange or a bit operation on their addresses reads or rewrites the pointer. Software can therefore set a pointer, walk a buffer with automatic pointer stepping, and read back the pointer after the walk.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the unit is idle. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. The source must hold its fields stable until that edge, and it may keep `cmd_valid` high while `cmd_ready` is low without losing the command. Results come back on a one-cycle `done` pulse with a `skip` flag. There is no back-pressure on the result side.

Top module: `acc_operand_unit`

## Requirements
- R1: A synchronous reset clears the accumulator, both pointers and every memory byte. During and after reset, `cmd_ready` is 1 and `done` and `skip` are 0.
- R2: A command accepted on edge k keeps `cmd_ready` low for two cycles, a read cycle and then a write cycle. `done` is high for exactly one cycle, the one after edge k+2, and `cmd_ready` is high again in that same cycle.
- R3: With mode 0 (direct), the operand byte is the data address.
- R4: With mode 1 (indirect), the address is P0 when `cmd_ptr_sel`=0 and P1 when it is 1. The pointer is not changed.
- R5: Mode 2 (post-increment) and mode 3 (post-decrement) use the selected pointer as the address and then step it by +1 or −1, modulo 256, after the access.
- R6: Op 1 (exchange) writes the old accumulator into the addressed byte and loads the old byte into the accumulator, both in one operation.
- R7: Op 0 (load) puts the addressed byte into the accumulator. With mode 4 (immediate), it puts the operand byte there instead. Mode 4 with any other op, ops 5 to 7 and modes 5 to 7 change nothing, but they still complete with `done`.
- R8: Op 2 (set) and op 3 (clear) force bit `cmd_bit` of the addressed byte to 1 or 0 and leave its other bits and the accumulator unchanged.
- R9: Op 4 (test) drives `skip` to 1 with `done` when the addressed bit is 1, and changes no state. `skip` is 0 on every other cycle.
- R10: Address 0xFE maps to P0 and address 0xFC maps to P1, for reads, writes and bit operations alike.
- R11: When a post-modify op also writes the pointer it steps, the stepped value is what remains.
- R12: Addresses 0x00–0x7F hold memory bytes. Any other address that is not a pointer reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted this edge if valid |
| cmd_op | input | 3 | 0 load, 1 exchange, 2 set bit, 3 clear bit, 4 test bit |
| cmd_mode | input | 3 | 0 direct, 1 indirect, 2 post-inc, 3 post-dec, 4 immediate |
| cmd_ptr_sel | input | 1 | Pointer choice, 0 = P0, 1 = P1 |
| cmd_bit | input | 3 | Bit index for bit operations |
| cmd_operand | input | 8 | Direct address or immediate data |
| done | output | 1 | One-cycle completion pulse |
| skip | output | 1 | Bit-test result, valid with done |
| acc | output | 8 | Accumulator |

## Verification
Some behaviour is checked on every cycle by the assertions: the single-cycle `done` pulse, `cmd_ready` dropping after acceptance, `skip` appearing only with `done`, exchange and immediate-load accumulator results, set-bit write data, and the pointer holding the stepped value after a post-modify. Other behaviour only the bench's scenarios can show, because it needs a chain of operations to become visible. This covers pointer aliasing at 0xFE and 0xFC, the 0xFF→0x00 wrap, the priority of the step over a same-pointer write, ignored writes to unmapped addresses, no-op codes, and the full memory clear of a mid-run reset.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_XCH  = 3'd1,
    OP_SETB = 3'd2,
    OP_CLRB = 3'd3,
    OP_TSTB = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    MD_DIRECT = 3'd0,
    MD_IND    = 3'd1,
    MD_PINC   = 3'd2,
    MD_PDEC   = 3'd3,
    MD_IMM    = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } state_e;
endpackage

// File: rtl/amu_addr_gen.sv
module amu_addr_gen
  import amu_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [2:0]    mode,
  input  logic          ptr_sel,
  input  logic [AW-1:0] operand,
  input  logic [AW-1:0] ptr_p0,
  input  logic [AW-1:0] ptr_p1,
  output logic [AW-1:0] addr,
  output logic          uses_mem,
  output step_e         step
);
  logic [AW-1:0] sel_ptr;

  assign sel_ptr = ptr_sel ? ptr_p1 : ptr_p0;

  always_comb begin
    addr     = operand;
    uses_mem = 1'b1;
    step     = STEP_NONE;
    case (mode)
      MD_DIRECT: addr = operand;
      MD_IND:    addr = sel_ptr;
      MD_PINC: begin
        addr = sel_ptr;
        step = STEP_INC;
      end
      MD_PDEC: begin
        addr = sel_ptr;
        step = STEP_DEC;
      end
      default:   uses_mem = 1'b0;
    endcase
  end
endmodule

// File: rtl/amu_bit_unit.sv
module amu_bit_unit
  import amu_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int BW = $clog2(DW)
) (
  input  logic [2:0]    op,
  input  logic [BW-1:0] bit_idx,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          bit_val
);
  logic [DW-1:0] mask;

  assign mask    = DW'(1) << bit_idx;
  assign bit_val = |(din & mask);

  always_comb begin
    case (op)
      OP_SETB: dout = din | mask;
      OP_CLRB: dout = din & ~mask;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/amu_store.sv
module amu_store
  import amu_pkg::*;
#(
  parameter int DW        = DATA_W,
  parameter int AW        = ADDR_W,
  parameter int MEM_DEPTH = 128,
  parameter logic [AW-1:0] P0_ADDR = 8'hFE,
  parameter logic [AW-1:0] P1_ADDR = 8'hFC,
  localparam int IW = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          upd_en,
  input  logic          upd_sel,
  input  logic [AW-1:0] upd_val,
  output logic [AW-1:0] ptr_p0,
  output logic [AW-1:0] ptr_p1
);
  logic [DW-1:0] mem [MEM_DEPTH];

  function automatic logic in_mem(input logic [AW-1:0] a);
    return a < AW'(MEM_DEPTH);
  endfunction

  always_comb begin
    if (raddr == P0_ADDR)      rdata = DW'(ptr_p0);
    else if (raddr == P1_ADDR) rdata = DW'(ptr_p1);
    else if (in_mem(raddr))    rdata = mem[raddr[IW-1:0]];
    else                       rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_p0 <= '0;
      ptr_p1 <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we) begin
        if (waddr == P0_ADDR)      ptr_p0 <= AW'(wdata);
        else if (waddr == P1_ADDR) ptr_p1 <= AW'(wdata);
        else if (in_mem(waddr))    mem[waddr[IW-1:0]] <= wdata;
      end
      // pointer step overrides a same-cycle write to that pointer
      if (upd_en) begin
        if (upd_sel) ptr_p1 <= upd_val;
        else         ptr_p0 <= upd_val;
      end
    end
  end

  // R11
  p0_step_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_sel) |=> ptr_p0 == $past(upd_val));
  // R11
  p1_step_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_sel) |=> ptr_p1 == $past(upd_val));
endmodule

// File: rtl/acc_operand_unit.sv
module acc_operand_unit
  import amu_pkg::*;
#(
  parameter int DW        = DATA_W,
  parameter int AW        = ADDR_W,
  parameter int MEM_DEPTH = 128,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [2:0]    cmd_mode,
  input  logic          cmd_ptr_sel,
  input  logic [BW-1:0] cmd_bit,
  input  logic [AW-1:0] cmd_operand,
  output logic          done,
  output logic          skip,
  output logic [DW-1:0] acc
);
  state_e        state;
  logic [2:0]    op_q, mode_q;
  logic          sel_q;
  logic [BW-1:0] bit_q;
  logic [AW-1:0] opnd_q;
  logic [DW-1:0] rdata_q;

  logic [AW-1:0] addr, ptr_p0, ptr_p1, sel_ptr, upd_val;
  logic          uses_mem, op_known, mem_op, is_imm_ld;
  step_e         step;
  logic [DW-1:0] rdata, bit_dout, wdata;
  logic          bit_val, we, upd_en;

  amu_addr_gen #(.AW(AW)) u_addr (
    .mode(mode_q), .ptr_sel(sel_q), .operand(opnd_q),
    .ptr_p0(ptr_p0), .ptr_p1(ptr_p1),
    .addr(addr), .uses_mem(uses_mem), .step(step)
  );

  amu_bit_unit #(.DW(DW)) u_bit (
    .op(op_q), .bit_idx(bit_q), .din(rdata_q),
    .dout(bit_dout), .bit_val(bit_val)
  );

  amu_store #(.DW(DW), .AW(AW), .MEM_DEPTH(MEM_DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .raddr(addr), .rdata(rdata),
    .we(we), .waddr(addr), .wdata(wdata),
    .upd_en(upd_en), .upd_sel(sel_q), .upd_val(upd_val),
    .ptr_p0(ptr_p0), .ptr_p1(ptr_p1)
  );

  assign op_known  = op_q <= 3'(OP_TSTB);
  assign mem_op    = op_known && uses_mem;
  assign is_imm_ld = (op_q == OP_LOAD) && (mode_q == MD_IMM);
  assign cmd_ready = (state == ST_IDLE);

  assign sel_ptr = sel_q ? ptr_p1 : ptr_p0;
  assign upd_val = (step == STEP_INC) ? sel_ptr + 1'b1 : sel_ptr - 1'b1;
  assign upd_en  = (state == ST_WRITE) && mem_op && (step != STEP_NONE);
  assign we      = (state == ST_WRITE) && mem_op &&
                   (op_q == OP_XCH || op_q == OP_SETB || op_q == OP_CLRB);
  assign wdata   = (op_q == OP_XCH) ? acc : bit_dout;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      acc     <= '0;
      done    <= 1'b0;
      skip    <= 1'b0;
      op_q    <= '0;
      mode_q  <= '0;
      sel_q   <= 1'b0;
      bit_q   <= '0;
      opnd_q  <= '0;
      rdata_q <= '0;
    end else begin
      done <= 1'b0;
      skip <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          mode_q <= cmd_mode;
          sel_q  <= cmd_ptr_sel;
          bit_q  <= cmd_bit;
          opnd_q <= cmd_operand;
          state  <= ST_READ;
        end
        ST_READ: begin
          rdata_q <= rdata;
          state   <= ST_WRITE;
        end
        ST_WRITE: begin
          state <= ST_IDLE;
          done  <= 1'b1;
          skip  <= mem_op && (op_q == OP_TSTB) && bit_val;
          if (is_imm_ld)
            acc <= DW'(opnd_q);
          else if (mem_op && (op_q == OP_LOAD || op_q == OP_XCH))
            acc <= rdata_q;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R9
  skip_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    skip |-> done);
  // R6
  xch_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE && op_q == OP_XCH && mem_op) |=> acc == $past(rdata_q));
  // R7
  imm_load_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE && is_imm_ld) |=> acc == DW'($past(opnd_q)));
  // R8
  set_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (we && op_q == OP_SETB) |-> wdata[bit_q]);
endmodule

// File: tb/tb_acc_operand_unit.sv
module tb_acc_operand_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [2:0] cmd_op, cmd_mode, cmd_bit;
  logic       cmd_ptr_sel;
  logic [7:0] cmd_operand;
  logic       done, skip;
  logic [7:0] acc;

  int total = 0;
  int bad   = 0;
  int lat_bad = 0;
  int busy_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  acc_operand_unit dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mode(cmd_mode), .cmd_ptr_sel(cmd_ptr_sel),
    .cmd_bit(cmd_bit), .cmd_operand(cmd_operand),
    .done(done), .skip(skip), .acc(acc)
  );

  // op, mode, sel, bit, operand, expected acc, expected skip
  localparam int NV = 39;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0,3'd4,1'b0,3'd0,8'h5A,8'h5A,1'b0}, // R7 imm load
    {3'd1,3'd0,1'b0,3'd0,8'h10,8'h00,1'b0}, // R6 xch direct
    {3'd0,3'd0,1'b0,3'd0,8'h10,8'h5A,1'b0}, // R3 direct load
    {3'd0,3'd4,1'b0,3'd0,8'h05,8'h05,1'b0},
    {3'd1,3'd0,1'b0,3'd0,8'hFE,8'h00,1'b0}, // R10 write P0
    {3'd0,3'd4,1'b0,3'd0,8'h62,8'h62,1'b0},
    {3'd1,3'd2,1'b0,3'd0,8'h00,8'h00,1'b0}, // R5 post-inc xch
    {3'd0,3'd0,1'b0,3'd0,8'hFE,8'h06,1'b0}, // R5 P0 stepped
    {3'd0,3'd4,1'b0,3'd0,8'h03,8'h03,1'b0},
    {3'd1,3'd3,1'b1,3'd0,8'h00,8'h00,1'b0}, // R5 post-dec P1
    {3'd0,3'd0,1'b0,3'd0,8'hFC,8'hFF,1'b0}, // R5 wrap 00->FF
    {3'd2,3'd0,1'b0,3'd2,8'h10,8'hFF,1'b0}, // R8 set bit2
    {3'd0,3'd0,1'b0,3'd0,8'h10,8'h5E,1'b0}, // R8
    {3'd4,3'd0,1'b0,3'd2,8'h10,8'h5E,1'b1}, // R9 test set bit
    {3'd3,3'd0,1'b0,3'd6,8'h10,8'h5E,1'b0}, // R8 clear bit6
    {3'd4,3'd0,1'b0,3'd6,8'h10,8'h5E,1'b0}, // R9 test clear bit
    {3'd0,3'd0,1'b0,3'd0,8'h10,8'h1E,1'b0},
    {3'd2,3'd0,1'b0,3'd0,8'hFE,8'h1E,1'b0}, // R10 bit op on P0
    {3'd0,3'd0,1'b0,3'd0,8'hFE,8'h07,1'b0},
    {3'd4,3'd2,1'b1,3'd7,8'h00,8'h07,1'b0}, // R12 FF reads 0, R5 wrap
    {3'd0,3'd0,1'b0,3'd0,8'hFC,8'h00,1'b0},
    {3'd0,3'd1,1'b1,3'd0,8'h00,8'h03,1'b0}, // R4 indirect P1
    {3'd0,3'd0,1'b0,3'd0,8'hFC,8'h00,1'b0}, // R4 P1 unchanged
    {3'd0,3'd3,1'b0,3'd0,8'h00,8'h00,1'b0},
    {3'd0,3'd3,1'b0,3'd0,8'h00,8'h00,1'b0},
    {3'd0,3'd1,1'b0,3'd0,8'h00,8'h62,1'b0}, // R4 indirect P0
    {3'd1,3'd4,1'b0,3'd0,8'h77,8'h62,1'b0}, // R7 imm xch no-op
    {3'd0,3'd0,1'b0,3'd0,8'h10,8'h1E,1'b0},
    {3'd0,3'd4,1'b0,3'd0,8'hFE,8'hFE,1'b0},
    {3'd1,3'd0,1'b0,3'd0,8'hFE,8'h05,1'b0},
    {3'd1,3'd2,1'b0,3'd0,8'h00,8'hFE,1'b0}, // R11 step vs write
    {3'd0,3'd0,1'b0,3'd0,8'hFE,8'hFF,1'b0}, // R11
    {3'd0,3'd4,1'b0,3'd0,8'hAA,8'hAA,1'b0},
    {3'd1,3'd0,1'b0,3'd0,8'h90,8'h00,1'b0}, // R12 unmapped
    {3'd0,3'd0,1'b0,3'd0,8'h90,8'h00,1'b0}, // R12 write ignored
    {3'd2,3'd0,1'b0,3'd4,8'hFC,8'h00,1'b0}, // R10 set bit on P1
    {3'd4,3'd0,1'b0,3'd4,8'hFC,8'h00,1'b1}, // R10
    {3'd4,3'd1,1'b1,3'd4,8'h00,8'h00,1'b1}, // R4 P1=10
    {3'd5,3'd0,1'b0,3'd0,8'h10,8'h00,1'b0}  // R7 unknown op
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [2:0] md, input logic sl,
                        input logic [2:0] bt, input logic [7:0] opnd);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_mode = md; cmd_ptr_sel = sl;
    cmd_bit = bt; cmd_operand = opnd;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    while (!done && n < 10) begin
      if (!cmd_ready) ; else busy_bad++;
      @(negedge clk);
      n++;
    end
    if (n != 3) lat_bad++;
    if (!cmd_ready) busy_bad++;
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_mode = '0;
    cmd_ptr_sel = 1'b0; cmd_bit = '0; cmd_operand = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 acc", acc, 8'h00);
    check("R1 ready", {7'd0, cmd_ready}, 8'h01);
    check("R1 done", {7'd0, done}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][26:24], VEC[i][23:21], VEC[i][20], VEC[i][19:17], VEC[i][16:9]);
      check($sformatf("vec%0d acc R3/R6/R7", i), acc, VEC[i][8:1]);
      check($sformatf("vec%0d skip R9", i), {7'd0, skip}, {7'd0, VEC[i][0]});
    end

    // R2 latency and busy window
    check("R2 done latency", 8'(lat_bad), 8'h00);
    check("R2 ready while busy", 8'(busy_bad), 8'h00);
    // R2 / R9 done and skip fall after one cycle
    @(negedge clk);
    check("R2 done one cycle", {7'd0, done}, 8'h00);
    check("R9 skip idle", {7'd0, skip}, 8'h00);

    // R1 mid-run reset clears memory and pointers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 acc after reset", acc, 8'h00);
    run_op(3'd0, 3'd0, 1'b0, 3'd0, 8'h10);
    check("R1 mem cleared", acc, 8'h00);
    run_op(3'd0, 3'd0, 1'b0, 3'd0, 8'hFC);
    check("R1 P1 cleared", acc, 8'h00);
    run_op(3'd0, 3'd1, 1'b0, 3'd0, 8'h00);
    check("R1 mem00 cleared", acc, 8'h00);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule